// File: doc/BRIEF.md
# Converter Result Byte Sender

This block hands a finished converter result, 12 magnitude bits with a sign flag and an overrange flag, to either a parallel bus or a serial transmitter's buffer register. The result is sent as two bytes: the high byte carries the top four magnitude bits and both flags, and the low byte carries the bottom eight magnitude bits. In direct mode the block only gates the byte output enables from three active-low enable inputs driven by a host. In handshake mode it runs the transfer itself. It drives a load strobe and one flag per byte, and it waits on a ready input from the receiver before moving to each step.

The block runs from one system clock at twice the rate of the converter's internal clock. A phase bit splits the system edges into internal rising and falling events. The ready input is sampled only on falling events, and the strobes and enables change only on rising events. Handshake mode can be entered in two ways. A level on the mode input enters it after every new result is stored. A rising edge on the mode input enters it at once. While a transfer runs, a busy output stops the converter from storing new results.

Top module: `adc_byte_sender`

## Requirements
- R1: The high byte output is {ovr, pol, mag[11:8]} (bit 5 down to bit 0). The low byte output is mag[7:0]. Each byte output reads zero when its enable is low. In handshake mode the high byte is always sent first.
- R2: With mode held high and the block idle, a one-cycle latch pulse makes busy rise two system clocks later.
- R3: A rising edge on mode while idle makes busy rise one system clock later. If the edge arrives in the same cycle as a latch pulse, entry is delayed by one more clock.
- R4: While busy, changes on mode and latch pulses have no effect. No new transfer starts after the current one ends unless a new trigger arrives.
- R5: The control-pin drive output is high whenever mode is high or busy is high, and low otherwise. While idle, the load strobe and both byte flags read high.
- R6: After handshake entry, nothing is driven until ready is sampled high on a falling event. On the following rising event, the load strobe and the high flag go low and the high byte enable goes high together.
- R7: With ready held high, each byte has its load strobe low for exactly 2 system clocks, its data enabled for 3, and its flag low for 4.
- R8: If ready is low, the current byte stays driven with its flag low and the load strobe high, for as long as needed. Once ready is sensed high, the byte enable drops first, and the flag rises one system clock later.
- R9: In the same clock that the high flag rises, the load strobe and the low flag go low and the low byte enable goes high.
- R10: In direct mode (mode low, not busy), a byte is enabled only while the chip-enable input and that byte's enable input are both low.
- R11: Busy falls in the same clock that the low flag rises, one system clock after the low byte enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the internal converter rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Output mode: low is direct, high is handshake |
| send_i | input | 1 | Receiver ready to accept a byte |
| latch_i | input | 1 | One-cycle pulse: a new result is being stored |
| mag_i | input | 12 | Stored result magnitude |
| pol_i | input | 1 | Stored polarity, high for positive |
| ovr_i | input | 1 | Stored overrange flag |
| ce_n_i | input | 1 | Direct mode chip enable, active low |
| hben_n_i | input | 1 | Direct mode high byte enable, active low |
| lben_n_i | input | 1 | Direct mode low byte enable, active low |
| ce_load_n_o | output | 1 | Load strobe, active low, handshake mode |
| hben_n_o | output | 1 | High byte flag, active low, handshake mode |
| lben_n_o | output | 1 | Low byte flag, active low, handshake mode |
| ctl_oe_o | output | 1 | Control pins are driven as outputs |
| hi_byte_o | output | 6 | High byte data |
| hi_oe_o | output | 1 | High byte output enable |
| lo_byte_o | output | 8 | Low byte data |
| lo_oe_o | output | 1 | Low byte output enable |
| busy_o | output | 1 | Transfer in progress, blocks result storage |

## Verification
The transfer is run in four ways. Ready held high throughout gives the unstalled pulse widths. Ready low at entry shows that nothing moves before the first acceptance. Ready dropped during each byte shows the hold state and the order of release between data and flag. Mode toggling and latch pulses during a stall show that these inputs are ignored. Three entry paths are timed separately by when busy rises: the level trigger, the plain mode edge, and a mode edge that coincides with a latch pulse. Direct-mode gating is checked with every relevant combination of the chip-enable and byte-enable inputs.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SENSE_HI,
        ST_ARM_HI,
        ST_LD_HI,
        ST_HOLD_HI,
        ST_REL_HI,
        ST_LD_LO,
        ST_HOLD_LO,
        ST_REL_LO
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      ph;      // 1: this edge is an internal falling event
    } seq_regs_t;

    typedef struct packed {
        logic mode;
        logic pend;
    } entry_regs_t;

endpackage

// File: rtl/adc_hs_entry.sv
module adc_hs_entry
    import adc_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic latch_i,
    input  logic busy_i,
    output logic enter_o
);

    entry_regs_t r_q, r_d;
    logic        rise;
    logic        req;

    always_comb begin
        r_d      = r_q;
        rise     = mode_i & ~r_q.mode;
        req      = (rise | (mode_i & latch_i)) & ~busy_i & ~r_q.pend;
        enter_o  = (req & ~latch_i) | r_q.pend;
        r_d.mode = mode_i;
        r_d.pend = req & latch_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= 1'b1;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R4: no entry request while a transfer is running
    p_busy_blocks_entry_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !enter_o);

    // R3: a trigger that coincides with a latch pulse enters on the next clock
    p_latch_defers_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && latch_i && !busy_i && !r_q.pend) |-> (!enter_o ##1 enter_o));

endmodule

// File: rtl/adc_hs_seq.sv
module adc_hs_seq
    import adc_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic send_i,
    output logic busy_o,
    output logic ce_n_o,
    output logic hben_n_o,
    output logic lben_n_o,
    output logic hi_drv_o,
    output logic lo_drv_o
);

    seq_regs_t r_q, r_d;
    logic      fall_ev;
    logic      rise_ev;

    always_comb begin
        r_d     = r_q;
        r_d.ph  = ~r_q.ph;
        fall_ev = r_q.ph;
        rise_ev = ~r_q.ph;
        unique case (r_q.state)
            ST_IDLE:     if (enter_i)           r_d.state = ST_SENSE_HI;
            ST_SENSE_HI: if (fall_ev && send_i) r_d.state = ST_ARM_HI;
            ST_ARM_HI:   if (rise_ev)           r_d.state = ST_LD_HI;
            ST_LD_HI:    if (rise_ev)           r_d.state = ST_HOLD_HI;
            ST_HOLD_HI:  if (fall_ev && send_i) r_d.state = ST_REL_HI;
            ST_REL_HI:   if (rise_ev)           r_d.state = ST_LD_LO;
            ST_LD_LO:    if (rise_ev)           r_d.state = ST_HOLD_LO;
            ST_HOLD_LO:  if (fall_ev && send_i) r_d.state = ST_REL_LO;
            ST_REL_LO:   if (rise_ev)           r_d.state = ST_IDLE;
            default:                            r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.ph    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o   = (r_q.state != ST_IDLE);
        ce_n_o   = !(r_q.state inside {ST_LD_HI, ST_LD_LO});
        hben_n_o = !(r_q.state inside {ST_LD_HI, ST_HOLD_HI, ST_REL_HI});
        lben_n_o = !(r_q.state inside {ST_LD_LO, ST_HOLD_LO, ST_REL_LO});
        hi_drv_o = (r_q.state inside {ST_LD_HI, ST_HOLD_HI});
        lo_drv_o = (r_q.state inside {ST_LD_LO, ST_HOLD_LO});
    end

    // R7: the load strobe is low for exactly one internal period
    p_load_width_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n_o) |=> (!ce_n_o ##1 ce_n_o));

    // R8: a byte is released only after ready was sampled high
    p_release_needs_send_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi_drv_o) || $fell(lo_drv_o)) |-> $past(send_i));

    // R8: the high flag rises half a period after its data is released
    p_flag_after_data_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_drv_o) |=> $rose(hben_n_o));

    // R9: the low byte starts in the clock the high flag rises
    p_low_start_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hben_n_o) |-> (!ce_n_o && !lben_n_o && lo_drv_o));

    // R6: the strobe never falls without a byte flag also low
    p_strobe_with_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n_o) |-> (hben_n_o != lben_n_o));

endmodule

// File: rtl/adc_hs_pins.sv
module adc_hs_pins #(
    parameter int MAG_W  = 12,
    parameter int BYTE_W = 8,
    localparam int HI_W  = MAG_W - BYTE_W + 2
) (
    input  logic              mode_i,
    input  logic              busy_i,
    input  logic              ce_n_i,
    input  logic              hben_n_i,
    input  logic              lben_n_i,
    input  logic              hi_drv_i,
    input  logic              lo_drv_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    output logic              ctl_oe_o,
    output logic [HI_W-1:0]   hi_byte_o,
    output logic              hi_oe_o,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic              lo_oe_o
);

    logic            direct_en;
    logic [HI_W-1:0] hi_pack;

    always_comb begin
        direct_en = ~mode_i & ~busy_i;
        ctl_oe_o  = mode_i | busy_i;
        hi_pack   = {ovr_i, pol_i, mag_i[MAG_W-1:BYTE_W]};
        hi_oe_o   = busy_i ? hi_drv_i : (direct_en & ~ce_n_i & ~hben_n_i);
        lo_oe_o   = busy_i ? lo_drv_i : (direct_en & ~ce_n_i & ~lben_n_i);
    end

    for (genvar i = 0; i < HI_W; i++) begin : g_hi_gate
        assign hi_byte_o[i] = hi_pack[i] & hi_oe_o;
    end
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lo_gate
        assign lo_byte_o[i] = mag_i[i] & lo_oe_o;
    end

endmodule

// File: rtl/adc_byte_sender.sv
module adc_byte_sender #(
    parameter int MAG_W  = 12,
    parameter int BYTE_W = 8,
    localparam int HI_W  = MAG_W - BYTE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              send_i,
    input  logic              latch_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    input  logic              ce_n_i,
    input  logic              hben_n_i,
    input  logic              lben_n_i,
    output logic              ce_load_n_o,
    output logic              hben_n_o,
    output logic              lben_n_o,
    output logic              ctl_oe_o,
    output logic [HI_W-1:0]   hi_byte_o,
    output logic              hi_oe_o,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic              lo_oe_o,
    output logic              busy_o
);

    logic enter;
    logic hi_drv;
    logic lo_drv;

    adc_hs_entry u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .latch_i (latch_i),
        .busy_i  (busy_o),
        .enter_o (enter)
    );

    adc_hs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (enter),
        .send_i   (send_i),
        .busy_o   (busy_o),
        .ce_n_o   (ce_load_n_o),
        .hben_n_o (hben_n_o),
        .lben_n_o (lben_n_o),
        .hi_drv_o (hi_drv),
        .lo_drv_o (lo_drv)
    );

    adc_hs_pins #(.MAG_W(MAG_W), .BYTE_W(BYTE_W)) u_pins (
        .mode_i    (mode_i),
        .busy_i    (busy_o),
        .ce_n_i    (ce_n_i),
        .hben_n_i  (hben_n_i),
        .lben_n_i  (lben_n_i),
        .hi_drv_i  (hi_drv),
        .lo_drv_i  (lo_drv),
        .mag_i     (mag_i),
        .pol_i     (pol_i),
        .ovr_i     (ovr_i),
        .ctl_oe_o  (ctl_oe_o),
        .hi_byte_o (hi_byte_o),
        .hi_oe_o   (hi_oe_o),
        .lo_byte_o (lo_byte_o),
        .lo_oe_o   (lo_oe_o)
    );

    // R10: direct mode with chip enable high drives no byte
    p_direct_ce_gate_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !busy_o && ce_n_i) |-> (!hi_oe_o && !lo_oe_o));

    // R5: idle control pins rest high
    p_idle_pins_high_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ce_load_n_o && hben_n_o && lben_n_o));

    // R11: busy clears together with the low flag rising
    p_exit_with_flag_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (lben_n_o && $past(!lben_n_o)));

    // R1: the two bytes are never enabled together
    p_one_byte_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(hi_oe_o && lo_oe_o));

endmodule

// File: tb/adc_byte_sender_tb.sv
module adc_byte_sender_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0, send_i = 1'b0, latch_i = 1'b0;
    logic [11:0] mag_i = '0;
    logic        pol_i = 1'b0, ovr_i = 1'b0;
    logic        ce_n_i = 1'b1, hben_n_i = 1'b1, lben_n_i = 1'b1;
    logic        ce_load_n_o, hben_n_o, lben_n_o, ctl_oe_o;
    logic [5:0]  hi_byte_o;
    logic        hi_oe_o;
    logic [7:0]  lo_byte_o;
    logic        lo_oe_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_byte_sender u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .send_i(send_i),
        .latch_i(latch_i), .mag_i(mag_i), .pol_i(pol_i), .ovr_i(ovr_i),
        .ce_n_i(ce_n_i), .hben_n_i(hben_n_i), .lben_n_i(lben_n_i),
        .ce_load_n_o(ce_load_n_o), .hben_n_o(hben_n_o), .lben_n_o(lben_n_o),
        .ctl_oe_o(ctl_oe_o), .hi_byte_o(hi_byte_o), .hi_oe_o(hi_oe_o),
        .lo_byte_o(lo_byte_o), .lo_oe_o(lo_oe_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int hi_exp();
        return {ovr_i, pol_i, mag_i[11:8]};
    endfunction

    task automatic wait_ce_low(output int found);
        found = 0;
        for (int i = 0; i < 40; i++) begin
            if (!ce_load_n_o) begin found = 1; break; end
            tick(1);
        end
    endtask

    // Ready held high: capture 10 samples from the first strobe
    task automatic run_free(input string tag);
        int f;
        int ce_lo = 0, hoe = 0, hb = 0, lb = 0, loe = 0;
        logic busy_s [10];
        wait_ce_low(f);
        chk({tag, " R6 strobe seen"}, f, 1);
        chk({tag, " R6 high flag low with strobe"}, hben_n_o, 0);
        chk({tag, " R1 high byte value"}, hi_byte_o, hi_exp());
        for (int k = 0; k < 10; k++) begin
            if (k < 4 && !ce_load_n_o) ce_lo++;
            if (hi_oe_o) hoe++;
            if (!hben_n_o) hb++;
            if (!lben_n_o) lb++;
            if (lo_oe_o) loe++;
            if (k == 4) begin
                chk({tag, " R9 low start strobe"}, ce_load_n_o, 0);
                chk({tag, " R9 low start oe"}, lo_oe_o, 1);
                chk({tag, " R1 low byte value"}, lo_byte_o, mag_i[7:0]);
            end
            busy_s[k] = busy_o;
            tick(1);
        end
        chk({tag, " R7 strobe width"}, ce_lo, 2);
        chk({tag, " R7 high data width"}, hoe, 3);
        chk({tag, " R7 high flag width"}, hb, 4);
        chk({tag, " R7 low flag width"}, lb, 4);
        chk({tag, " R7 low data width"}, loe, 3);
        chk({tag, " R11 busy at last flag"}, busy_s[7], 1);
        chk({tag, " R11 busy cleared"}, busy_s[8], 0);
    endtask

    task automatic t_reset();
        chk("R5 reset busy", busy_o, 0);
        chk("R5 reset pins", {ce_load_n_o, hben_n_o, lben_n_o}, 7);
        chk("R5 reset ctl drive", ctl_oe_o, 0);
        chk("R10 reset no oe", {hi_oe_o, lo_oe_o}, 0);
    endtask

    task automatic t_direct();
        mag_i = 12'hA5C; pol_i = 1; ovr_i = 0;
        ce_n_i = 0; hben_n_i = 0; lben_n_i = 1; tick(1);
        chk("R10 high only oe", {hi_oe_o, lo_oe_o}, 2);
        chk("R1 direct high byte", hi_byte_o, 6'h1A);
        hben_n_i = 1; lben_n_i = 0; tick(1);
        chk("R10 low only oe", {hi_oe_o, lo_oe_o}, 1);
        chk("R1 direct low byte", lo_byte_o, 8'h5C);
        ce_n_i = 1; hben_n_i = 0; tick(1);
        chk("R10 chip disabled", {hi_oe_o, lo_oe_o}, 0);
        chk("R1 disabled byte reads zero", hi_byte_o, 0);
        ce_n_i = 0; hben_n_i = 1; lben_n_i = 1; tick(1);
        chk("R10 no byte selected", {hi_oe_o, lo_oe_o}, 0);
        ce_n_i = 1;
        mode_i = 0; tick(1);
        chk("R5 direct ctl drive low", ctl_oe_o, 0);
    endtask

    task automatic t_edge_entry();
        mag_i = 12'h3E7; pol_i = 0; ovr_i = 1; send_i = 1;
        mode_i = 1; tick(1);
        chk("R3 edge entry one clock", busy_o, 1);
        chk("R5 ctl drive in handshake", ctl_oe_o, 1);
        run_free("edge");
        tick(6);
        chk("R4 no reentry with mode held", busy_o, 0);
        chk("R5 idle pins high with mode high", {ctl_oe_o, ce_load_n_o, hben_n_o, lben_n_o}, 15);
    endtask

    task automatic t_level_entry();
        mag_i = 12'hC01; pol_i = 1; ovr_i = 1;
        latch_i = 1; tick(1); latch_i = 0;
        chk("R2 level entry not yet", busy_o, 0);
        tick(1);
        chk("R2 level entry after two", busy_o, 1);
        run_free("level");
        tick(4);
    endtask

    task automatic t_edge_with_latch();
        mode_i = 0; tick(3);
        mag_i = 12'h0FF; pol_i = 0; ovr_i = 0;
        mode_i = 1; latch_i = 1; tick(1); latch_i = 0;
        chk("R3 deferred edge not yet", busy_o, 0);
        tick(1);
        chk("R3 deferred edge entered", busy_o, 1);
        run_free("defer");
        tick(4);
    endtask

    task automatic t_stall();
        int f, n;
        mode_i = 0; send_i = 0; tick(2);
        mag_i = 12'h96A; pol_i = 1; ovr_i = 0;
        mode_i = 1; tick(1);
        mode_i = 0;
        chk("R3 stall entry", busy_o, 1);
        tick(10);
        chk("R6 nothing before ready", {ce_load_n_o, hben_n_o, hi_oe_o}, 6);
        chk("R5 ctl drive while busy mode low", ctl_oe_o, 1);
        send_i = 1;
        wait_ce_low(f);
        chk("R6 high load after ready", f, 1);
        send_i = 0;
        tick(12);
        chk("R8 hold high byte", {hi_oe_o, hben_n_o, ce_load_n_o}, 5);
        mode_i = 1; tick(1); mode_i = 0; latch_i = 1; tick(1); latch_i = 0; tick(2);
        chk("R4 mode ignored mid transfer", {busy_o, hi_oe_o, hben_n_o, lben_n_o}, 13);
        send_i = 1;
        n = 0;
        while (hi_oe_o && n < 8) begin tick(1); n++; end
        chk("R8 high data released", hi_oe_o, 0);
        chk("R8 flag still low at release", hben_n_o, 0);
        send_i = 0;
        tick(1);
        chk("R8 flag high after half", hben_n_o, 1);
        chk("R9 low start", {ce_load_n_o, lben_n_o, lo_oe_o}, 1);
        tick(10);
        chk("R8 hold low byte", {lo_oe_o, lben_n_o, busy_o}, 5);
        chk("R1 stalled low byte", lo_byte_o, 8'h6A);
        send_i = 1;
        n = 0;
        while (lo_oe_o && n < 8) begin tick(1); n++; end
        chk("R11 busy at low release", {busy_o, lben_n_o}, 2);
        tick(1);
        chk("R11 exit after half", {busy_o, lben_n_o, ce_load_n_o}, 3);
        tick(10);
        chk("R4 no queued transfer", busy_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_direct();
        t_edge_entry();
        t_level_entry();
        t_edge_with_latch();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule